// File: doc/BRIEF.md
# Glitch-free system clock selector

This block produces a system clock from one of two free-running inputs: a master clock, which may be inverted before use, and the output of a phase-locked loop. The selected clock then goes through a pre-divider that passes it unchanged or halves its rate. When the selection changes while both inputs run, the changeover is clean. The old source is gated off on one of its own falling edges. The new source is gated on only after the old one has been seen off, and also on one of its own falling edges. The output therefore never carries a pulse narrower than a half period of the faster input.

Each source has an enable that is synchronised in that source's own clock domain. The enable of the other source is part of its input. A force control covers the case where the current source has already stopped. With force set, the enable of that source clears at once, and the switch completes on edges of the new clock alone. The glitch-free property is given up in that mode. The control fields are plain inputs. In a 16-bit control word they sit at select = bit 14, force = bit 13, divider = bits 12:11 and invert = bit 10, and the fields reset to zero.

Top module: `glitchfree_clk_sel`

## Requirements
- R1: While rst_ni is low, active_src_o is 2'b00 and sysclk_o is low. After release with sel_i = 0, active_src_o becomes 2'b01 within a few master clock cycles.
- R2: sel_i = 0 makes sysclk_o follow the master clock, and sel_i = 1 makes it follow the PLL clock. active_src_o bit 0 marks the master clock as gated on, and bit 1 marks the PLL clock.
- R3: The two enables are never high together. While both clocks run, no high or low pulse on sysclk_o across a change of selection or divider is shorter than a half period of the faster clock.
- R4: After sel_i changes with both clocks running, active_src_o shows the new source within SYNC_STAGES + 2 periods of the slower clock.
- R5: With force_i = 0, if the current source has stopped at low level, a change of sel_i stalls. active_src_o keeps the old value and sysclk_o stays low.
- R6: With force_i = 1, the enable of the deselected source clears without any edge of its clock, so active_src_o reads 2'b00. The new source is then enabled through its own synchroniser.
- R7: div_i = 2'b10 gives sysclk_o half the frequency of the selected clock, with a 50 % duty cycle.
- R8: div_i codes 2'b00, 2'b01 and 2'b11 all pass the selected clock undivided.
- R9: inv_i = 1 inverts the master clock before the selector. With the master clock selected and undivided, sysclk_o is then the complement of mclk_i.
- R10: A new divider setting takes effect at a falling edge of the selected clock, with the halving stage restarted low. Going from 2'b00 to 2'b10 while the clock is high, the first rising edge of sysclk_o comes one full source period after the next falling edge.
- R11: The pre-divider acts on the PLL clock in the same way as on the master clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk_i | input | 1 | Master clock |
| pll_clk_i | input | 1 | PLL output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Source select: 0 master, 1 PLL |
| force_i | input | 1 | Allow switching away from a stopped source |
| div_i | input | 2 | Pre-divider code: 2'b10 halves, others pass through |
| inv_i | input | 1 | Invert the master clock before selection |
| sysclk_o | output | 1 | System clock |
| active_src_o | output | 2 | Enable currently asserted, one bit per source |

## Verification
On every cycle, the assertions check the following:
- the two enables are never high together;
- an enable rises only while the other is low;
- force clears the deselected enable;
- the halving stage toggles on each falling edge;
- the halving stage restarts low whenever its mode changes.

Some behaviours can only be shown by the bench scenarios. These are the output frequencies, measured over a sweep of both sources and all four divider codes; the minimum pulse width across changeovers; the stall when a source is dead; the phase of the first divided edge; and the exact complement relation under inversion.

// File: rtl/gfclk_pkg.sv
package gfclk_pkg;

   localparam int NUM_SRC   = 2;
   localparam int DIV_W     = 2;
   localparam int SRC_MCLK  = 0;
   localparam int SRC_PLL   = 1;
   localparam logic [DIV_W-1:0] DIV_HALF_CODE = 2'b10;

   // only one code halves; the reserved codes fall back to pass-through
   function automatic logic div_is_half(input logic [DIV_W-1:0] code);
      return code == DIV_HALF_CODE;
   endfunction

endpackage

// File: rtl/gfclk_branch.sv
module gfclk_branch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic src_clk_i,
   input  logic rst_ni,
   input  logic want_i,
   input  logic force_i,
   input  logic other_en_i,
   output logic en_o
);

   localparam int LastStage = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("gfclk_branch: SYNC_STAGES must be at least 2");
   end

   logic                   clr;
   logic                   req;
   logic [SYNC_STAGES-1:0] shift_q;

   // reset, or forced release of a deselected source, clears without a clock edge
   assign clr = !rst_ni || (force_i && !want_i);
   assign req = want_i && !other_en_i;

   always_ff @(negedge src_clk_i or posedge clr) begin
      if (clr) shift_q <= '0;
      else     shift_q <= {shift_q[LastStage-1:0], req};
   end

   assign en_o = shift_q[LastStage];

   // R3
   en_after_other_chk: assert property (@(negedge src_clk_i) disable iff (clr)
      $rose(en_o) |-> !other_en_i)
      else $error("enable rose while the other source was enabled");

   // R6
   force_release_chk: assert property (@(negedge src_clk_i) disable iff (!rst_ni)
      (force_i && !want_i) |-> !en_o)
      else $error("forced deselect left the enable high");

endmodule

// File: rtl/gfclk_prediv.sv
module gfclk_prediv (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic div2_i,
   output logic clk_o
);

   logic mode_q;
   logic tog_q;

   // mode is taken on a falling edge, when the undivided clock is low
   always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= 1'b0;
         tog_q  <= 1'b0;
      end else if (mode_q != div2_i) begin
         mode_q <= div2_i;
         tog_q  <= 1'b0;
      end else if (mode_q) begin
         tog_q  <= !tog_q;
      end else begin
         tog_q  <= 1'b0;
      end
   end

   assign clk_o = mode_q ? tog_q : clk_i;

   // R10
   restart_low_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (mode_q != $past(mode_q)) |-> !tog_q)
      else $error("divider did not restart low on a mode change");

   // R7
   half_rate_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
      (mode_q && $past(mode_q)) |-> (tog_q != $past(tog_q)))
      else $error("halving stage missed a toggle");

endmodule

// File: rtl/glitchfree_clk_sel.sv
module glitchfree_clk_sel
   import gfclk_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               mclk_i,
   input  logic               pll_clk_i,
   input  logic               rst_ni,
   input  logic               sel_i,
   input  logic               force_i,
   input  logic [DIV_W-1:0]   div_i,
   input  logic               inv_i,
   output logic               sysclk_o,
   output logic [NUM_SRC-1:0] active_src_o
);

   localparam int LastSrc = NUM_SRC - 1;

   if (NUM_SRC != 2) begin : g_bad_src
      $error("glitchfree_clk_sel: exactly two sources are supported");
   end

   logic [NUM_SRC-1:0] src_clk;
   logic [NUM_SRC-1:0] want;
   logic [NUM_SRC-1:0] en;
   logic               muxed_clk;
   logic               div2;

   assign src_clk[SRC_MCLK] = mclk_i ^ inv_i;
   assign src_clk[SRC_PLL]  = pll_clk_i;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign want[g] = (sel_i == 1'(g));

      gfclk_branch #(
         .SYNC_STAGES(SYNC_STAGES)
      ) u_branch (
         .src_clk_i (src_clk[g]),
         .rst_ni    (rst_ni),
         .want_i    (want[g]),
         .force_i   (force_i),
         .other_en_i(en[LastSrc-g]),
         .en_o      (en[g])
      );
   end

   assign muxed_clk = |(src_clk & en);
   assign div2      = div_is_half(div_i);

   gfclk_prediv u_prediv (
      .clk_i (muxed_clk),
      .rst_ni(rst_ni),
      .div2_i(div2),
      .clk_o (sysclk_o)
   );

   assign active_src_o = en;

   always_comb begin
      if (rst_ni) begin
         // R3
         excl_en_chk: assert ($onehot0(en))
            else $error("both source enables high");
      end
   end

endmodule

// File: tb/glitchfree_clk_sel_tb.sv
`timescale 1ns/1ps
module glitchfree_clk_sel_tb;

   localparam real MPER = 8.0;
   localparam real PPER = 6.0;
   localparam real WIN  = 400.0;

   logic       mclk = 0, pll = 0, rst_n = 0;
   logic       sel = 0, frc = 0, inv = 0;
   logic [1:0] div = 2'b00;
   logic       sysclk;
   logic [1:0] status;
   bit         mrun = 1, prun = 1;

   int  checks = 0, fails = 0;
   int  edge_cnt = 0;
   bit  cnt_on = 0, pw_on = 0, overlap_seen = 0;
   realtime last_edge = 0, min_pulse = 1.0e9;

   always begin #4; if (mrun) mclk = ~mclk; end
   always begin #3; if (prun) pll = ~pll; end

   glitchfree_clk_sel u_dut (
      .mclk_i(mclk), .pll_clk_i(pll), .rst_ni(rst_n),
      .sel_i(sel), .force_i(frc), .div_i(div), .inv_i(inv),
      .sysclk_o(sysclk), .active_src_o(status)
   );

   always @(posedge sysclk) if (cnt_on) edge_cnt++;
   always @(sysclk) begin
      if (pw_on && (($realtime - last_edge) < min_pulse)) min_pulse = $realtime - last_edge;
      last_edge = $realtime;
   end
   always begin #1; if (rst_n && status == 2'b11) overlap_seen = 1; end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic count_edges(output int n);
      edge_cnt = 0; cnt_on = 1; #(WIN); cnt_on = 0; n = edge_cnt;
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #100000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      int n, exp_n, bad;
      realtime t0, dt;

      // R1 reset state
      #20;
      check(sysclk == 0, "R1", "sysclk in reset", int'(sysclk), 0);
      check(status == 2'b00, "R1", "status in reset", int'(status), 0);
      #1 rst_n = 1;
      #100;
      check(status == 2'b01, "R1", "status after reset", int'(status), 1);

      // sweep: both sources, all divider codes (R2 R4 R7 R8 R11 R3)
      @(posedge sysclk); #0.5; pw_on = 1;
      for (int s = 0; s < 2; s++) begin
         for (int c = 0; c < 4; c++) begin
            string tag;
            real   per;
            sel = s[0]; div = c[1:0];
            #100;
            check(status == (s ? 2'b10 : 2'b01), "R4", "active source", int'(status), s ? 2 : 1);
            per   = s ? PPER : MPER;
            exp_n = int'(WIN / (per * ((c == 2) ? 2.0 : 1.0)));
            count_edges(n);
            if (c == 2) tag = s ? "R11" : "R7";
            else if (c == 0) tag = "R2";
            else tag = "R8";
            check((n >= exp_n - 1) && (n <= exp_n + 1), tag, "edge count", n, exp_n);
         end
      end
      sel = 0; div = 2'b00;
      #100;
      pw_on = 0;
      check(min_pulse >= 2.9, "R3", "min pulse ps", int'(min_pulse * 1000.0), 3000);
      check(!overlap_seen, "R3", "both enables seen", int'(overlap_seen), 0);

      // R9 inversion
      bad = 0;
      for (int k = 0; k < 10; k++) begin
         @(posedge mclk); #1; if (sysclk !== 1'b1) bad++;
         @(negedge mclk); #1; if (sysclk !== 1'b0) bad++;
      end
      check(bad == 0, "R9", "follow uninverted mismatches", bad, 0);
      inv = 1; #100;
      bad = 0;
      for (int k = 0; k < 10; k++) begin
         @(posedge mclk); #1; if (sysclk !== 1'b0) bad++;
         @(negedge mclk); #1; if (sysclk !== 1'b1) bad++;
      end
      check(bad == 0, "R9", "inverted mismatches", bad, 0);
      inv = 0; #100;

      // R10 divider restart phase
      @(posedge mclk); t0 = $realtime; #1 div = 2'b10;
      @(posedge sysclk); dt = $realtime - t0;
      check((dt > 11.5) && (dt < 12.5), "R10", "first divided rise ps", int'(dt * 1000.0), 12000);
      t0 = $realtime;
      @(posedge sysclk); dt = $realtime - t0;
      check((dt > 15.5) && (dt < 16.5), "R7", "divided period ps", int'(dt * 1000.0), 16000);
      div = 2'b00; #100;

      // R5 stall with dead source
      @(negedge mclk); mrun = 0;
      #1 sel = 1;
      #200;
      check(status == 2'b01, "R5", "status while stalled", int'(status), 1);
      count_edges(n);
      check(n == 0, "R5", "edges while stalled", n, 0);
      check(sysclk == 0, "R5", "sysclk level while stalled", int'(sysclk), 0);

      // R6 force
      frc = 1; #1;
      check(status == 2'b00, "R6", "status right after force", int'(status), 0);
      #100;
      check(status == 2'b10, "R6", "status after forced switch", int'(status), 2);
      count_edges(n);
      exp_n = int'(WIN / PPER);
      check((n >= exp_n - 1) && (n <= exp_n + 1), "R6", "edges after forced switch", n, exp_n);

      mrun = 1; frc = 0; sel = 0;
      #200;
      check(status == 2'b01, "R4", "status after return", int'(status), 1);

      report();
      $finish;
   end

endmodule